// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a free-running watchdog. A counter advances on a selectable tick. When it reaches the period picked by a three-bit rate field, the block raises a one-cycle reset request. Software keeps the request from firing by writing a two-byte key to a service port before the period runs out. It must write 0x55 first and then 0xAA. Any other byte written to that port is taken as a sign of runaway code and raises the request at once.

The counter can advance on one of two tick strobes, an internal reference tick or an oscillator tick, picked by a select input. During stop mode the counter normally freezes. It keeps counting only under one combination: the low-power stop is the pseudo kind, the oscillator tick is selected, and the oscillator-continue control is set. A rate code of zero turns the watchdog off. Clock generation and the system reset sequencer are outside this block.

Top module: `keyed_watchdog`

## Requirements
- R1: A write of 0xAA that directly follows an accepted write of 0x55 clears the counter, so the next timeout comes a full period of counting ticks after that write.
- R2: While the watchdog is on, a write of any byte other than 0x55 or 0xAA makes `resetReq` high in the cycle after the write.
- R3: `resetReq` goes high after 2^E counting ticks since the counter was last cleared. E is 14, 16, 18, 20, 22, 23 or 24 for `rateSel` values 1 to 7 (with MIN_EXP=14). The counter never reaches or passes the period.
- R4: With `clkSel`=0 the counter advances on `refTick` only. With `clkSel`=1 it advances on `oscTick` only.
- R5: When `stopMode`=1, the counter holds its value unless `pseudoStop`, `clkSel` and `oscContinue` are all 1, in which case it keeps counting.
- R6: A write of 0xAA with no accepted 0x55 just before it leaves the counter unchanged and does not arm the service sequence.
- R7: With `rateSel`=0 the watchdog is off. The counter stays at zero, writes are ignored, and `resetReq` stays low.
- R8: Any change of `rateSel` clears the counter.
- R9: `resetReq` is 0 after system reset and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous system reset |
| rateSel | input | 3 | Timeout period code; 0 disables |
| clkSel | input | 1 | 0: count on refTick, 1: count on oscTick |
| stopMode | input | 1 | Chip is in stop mode |
| pseudoStop | input | 1 | Stop mode is the pseudo-stop variant |
| oscContinue | input | 1 | Oscillator keeps running in stop |
| refTick | input | 1 | Internal reference count strobe |
| oscTick | input | 1 | Oscillator count strobe |
| wrEn | input | 1 | Service-port write strobe |
| wrData | input | 8 | Service-port write byte |
| resetReq | output | 1 | One-cycle reset request |

## Verification
Assertions check several rules on every cycle: a bad key is always followed by a request, a clear always leaves the counter at zero, the counter stays below the selected period, a frozen stop mode keeps the count stable, a disabled watchdog never requests, and requests never come in adjacent cycles. The bench scenarios are needed to show the exact tick count to a timeout, that a valid key pair restarts the period, and that a lone 0xAA does not. They are also needed to show that ticks from the unselected source are ignored and that a blip of the rate field restarts the count. Only long runs observed at the request output can show these.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  // Strobes from the key/rate control to the counting datapath.
  typedef struct packed {
    logic clearCnt;
    logic badKey;
  } wdogStrb_t;

  // Period exponent for a rate code: four steps of two, then steps of one.
  function automatic int rateExp(input int minExp, input logic [2:0] rate);
    int r;
    r = int'(rate);
    if (r <= 5) return minExp + 2 * (r - 1);
    return minExp + 8 + (r - 5);
  endfunction

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int RATE_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output wdogStrb_t         strb
);

  logic [RATE_W-1:0] rateQ;
  logic armed;
  logic enabled, wrValid, isArm, isFire, svcDone, rateChg;

  assign enabled = |rateSel;
  assign wrValid = wrEn && enabled;
  assign isArm   = (wrData == KEY_ARM);
  assign isFire  = (wrData == KEY_FIRE);
  assign svcDone = wrValid && isFire && armed;
  assign rateChg = (rateSel != rateQ);

  always_comb begin
    strb.badKey   = wrValid && !isArm && !isFire;
    strb.clearCnt = svcDone || rateChg || strb.badKey || !enabled;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateQ <= '0;
      armed <= 1'b0;
    end else begin
      rateQ <= rateSel;
      if (!enabled)    armed <= 1'b0;
      else if (wrValid) armed <= isArm;
    end
  end

  // R6: a fire byte is never accepted without a preceding arm byte
  a_r6_fire_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && isFire) |=> !armed);

endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int RATE_W  = 3,
  parameter int MIN_EXP = 14,
  parameter int CNT_W   = MIN_EXP + 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              clkSel,
  input  logic              stopMode,
  input  logic              pseudoStop,
  input  logic              oscContinue,
  input  logic              refTick,
  input  logic              oscTick,
  input  wdogStrb_t         strb,
  output logic              resetReq
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   limitFull;
  logic [CNT_W-1:0] limitM1;
  logic tickSel, runOk, countEn, timeout;
  int   expSel;

  assign expSel    = rateExp(MIN_EXP, rateSel);
  assign limitFull = {{CNT_W{1'b0}}, 1'b1} << expSel;
  assign limitM1   = limitFull[CNT_W-1:0] - CNT_W'(1);

  assign tickSel = clkSel ? oscTick : refTick;
  assign runOk   = !stopMode || (pseudoStop && clkSel && oscContinue);
  assign countEn = tickSel && runOk;
  assign timeout = countEn && !strb.clearCnt && (cnt == limitM1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      resetReq <= 1'b0;
    end else begin
      if (strb.clearCnt || timeout) cnt <= '0;
      else if (countEn)             cnt <= cnt + CNT_W'(1);
      resetReq <= (strb.badKey || timeout) && !resetReq;
    end
  end

  // R2: a bad key always produces a request next cycle (none pending)
  a_r2_bad_key: assert property (@(posedge clk) disable iff (!rstN)
    (strb.badKey && !resetReq) |=> resetReq);
  // R1/R8: any clear strobe leaves the counter at zero
  a_r1_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCnt |=> (cnt == '0));
  // R3: counter stays below the selected period
  a_r3_bound: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearCnt |-> (cnt <= limitM1));
  // R5: frozen stop mode holds the count
  a_r5_stop_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stopMode && !(pseudoStop && clkSel && oscContinue) && !strb.clearCnt)
      |=> $stable(cnt));
  // R7: disabled watchdog never requests
  a_r7_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (rateSel == '0) |=> !resetReq);
  // R9: request is a single-cycle pulse
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdog_pkg::*;
#(
  parameter int RATE_W  = 3,
  parameter int DATA_W  = 8,
  parameter int MIN_EXP = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              clkSel,
  input  logic              stopMode,
  input  logic              pseudoStop,
  input  logic              oscContinue,
  input  logic              refTick,
  input  logic              oscTick,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              resetReq
);

  localparam int CNT_W = MIN_EXP + 10;

  wdogStrb_t strb;

  wdog_ctrl #(.RATE_W(RATE_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .rateSel(rateSel),
    .wrEn(wrEn), .wrData(wrData), .strb(strb)
  );

  wdog_count #(.RATE_W(RATE_W), .MIN_EXP(MIN_EXP), .CNT_W(CNT_W)) uCount (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .clkSel(clkSel),
    .stopMode(stopMode), .pseudoStop(pseudoStop), .oscContinue(oscContinue),
    .refTick(refTick), .oscTick(oscTick), .strb(strb), .resetReq(resetReq)
  );

endmodule

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] rateSel = 3'd0;
  logic clkSel = 1'b0, stopMode = 1'b0, pseudoStop = 1'b0, oscContinue = 1'b0;
  logic refTick = 1'b0, oscTick = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic resetReq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  localparam int PERIOD1 = 16384;  // rate 1 -> 2^14

  always #2.5 clk = ~clk;

  keyed_watchdog dut (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .clkSel(clkSel),
    .stopMode(stopMode), .pseudoStop(pseudoStop), .oscContinue(oscContinue),
    .refTick(refTick), .oscTick(oscTick), .wrEn(wrEn), .wrData(wrData),
    .resetReq(resetReq)
  );

  // Key vectors: {byte, expected resetReq one cycle later}
  localparam int NVEC = 14;
  localparam logic [8:0] VEC [NVEC] = '{
    {8'h55, 1'b0}, {8'hAA, 1'b0}, {8'hAA, 1'b0}, {8'h55, 1'b0},
    {8'h55, 1'b0}, {8'hAA, 1'b0}, {8'h12, 1'b1}, {8'h55, 1'b0},
    {8'h00, 1'b1}, {8'h55, 1'b0}, {8'hFF, 1'b1}, {8'hAA, 1'b0},
    {8'h54, 1'b1}, {8'hAA, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Clears the counter via disable, then applies a configuration with ticks off.
  task automatic prep(input logic [2:0] r, input logic cs, input logic st,
                      input logic ps, input logic oc);
    @(negedge clk);
    rateSel = 3'd0; refTick = 0; oscTick = 0; wrEn = 0;
    @(negedge clk);
    rateSel = r; clkSel = cs; stopMode = st; pseudoStop = ps; oscContinue = oc;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Turns ticks on, counts sampled cycles until resetReq; -1 if none by maxK.
  task automatic measure(input logic rt, input logic ot, input int svcAt,
                         input logic [7:0] keyA, input bit useB,
                         input int blipAt, input int maxK, output int got);
    got = -1;
    refTick = rt; oscTick = ot;
    for (int k = 1; k <= maxK; k++) begin
      @(negedge clk);
      if (resetReq) begin got = k; break; end
      wrEn = 0;
      if (k == svcAt) begin wrEn = 1; wrData = keyA; end
      if (k == svcAt + 1 && useB) begin wrEn = 1; wrData = 8'hAA; end
      if (k == blipAt) rateSel = 3'd2;
      if (k == blipAt + 1) rateSel = 3'd1;
    end
    wrEn = 0; refTick = 0; oscTick = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !done) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int got;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 reset state", resetReq, 0);

    // R2/R6 key vectors with ticks off
    prep(3'd1, 0, 0, 0, 0);
    for (int i = 0; i < NVEC; i++) begin
      wrEn = 1; wrData = VEC[i][8:1];
      @(negedge clk);
      check($sformatf("R2 vector %0d", i), resetReq, int'(VEC[i][0]));
    end
    wrEn = 0;
    @(negedge clk);
    check("R9 pulse ends", resetReq, 0);

    // R3/R4: timeout on refTick at rate 1
    prep(3'd1, 0, 0, 0, 0);
    measure(1, 0, -10, 8'h00, 0, -10, 17000, got);
    check("R3 R4 timeout ticks", got, PERIOD1);

    // R6: lone 0xAA does not restart
    prep(3'd1, 0, 0, 0, 0);
    measure(1, 0, 5000, 8'hAA, 0, -10, 17000, got);
    check("R6 lone AA", got, PERIOD1);

    // R1: 0x55 then 0xAA restarts the period
    prep(3'd1, 0, 0, 0, 0);
    measure(1, 0, 5000, 8'h55, 1, -10, 22000, got);
    check("R1 service restart", got, 5002 + PERIOD1);

    // R5: stop mode without pseudo-stop freezes
    prep(3'd1, 1, 1, 0, 1);
    measure(0, 1, -10, 8'h00, 0, -10, 17000, got);
    check("R5 stop frozen", got, -1);

    // R5: pseudo-stop, osc selected, continue set keeps counting
    prep(3'd1, 1, 1, 1, 1);
    measure(0, 1, -10, 8'h00, 0, -10, 17000, got);
    check("R5 stop running", got, PERIOD1);

    // R4: osc selected, only refTick toggles -> no count
    prep(3'd1, 1, 0, 0, 0);
    measure(1, 0, -10, 8'h00, 0, -10, 17000, got);
    check("R4 unselected tick", got, -1);

    // R7: disabled ignores bad key and ticks
    prep(3'd0, 0, 0, 0, 0);
    wrEn = 1; wrData = 8'h12;
    @(negedge clk);
    check("R7 disabled bad key", resetReq, 0);
    wrEn = 0;
    measure(1, 0, -10, 8'h00, 0, -10, 2000, got);
    check("R7 disabled no timeout", got, -1);

    // R8: rate blip 1->2->1 clears counter twice
    prep(3'd1, 0, 0, 0, 0);
    measure(1, 0, -10, 8'h00, 0, 10000, 27000, got);
    check("R8 rate change clears", got, 10002 + PERIOD1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule